// File: doc/BRIEF.md
# Register-Programmed Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable timing for a display interface, all in one pixel-clock domain. Software programs it through a small register write/read port. Horizontal timing uses an in-line pixel counter. Vertical timing does not count lines. Instead it compares a frame-wide pixel-clock position against absolute offsets, and those offsets may include a horizontal skew.

Within the display window, an optional inner active window can be enabled separately in each axis. Display pixels that fall outside an enabled inner window are filled with a border colour. Pixels inside it request live data from upstream. When upstream has no data, a programmable underflow colour replaces the live pixel. A select output reports which source is in use. A programmable fetch-start pulse marks a chosen frame position so that upstream fetch can begin outside the active lines. Frame and line counters can be read back while the engine runs.

Top module: `display_timing_gen`

## Requirements
- R1: The horizontal-timing register (index 2) holds the line total in bits [31:16] and the sync pulse width in bits [15:0]. The in-line position counts from 0 to total−1 and then wraps. The raw horizontal sync is active while the position is below the pulse width.
- R2: The frame position counts pixel clocks from 0 up to the frame-period register (index 3) minus one, then wraps to 0. The raw vertical sync is active while the frame position is below the vertical-pulse register (index 4), which is given in pixel clocks.
- R3: The raw data-enable is active when two conditions both hold. The in-line position must lie inside the horizontal display window (index 5: last pixel in [31:16], first pixel in [15:0], both inclusive). The frame position must lie between the display-begin register (index 6) and the display-end register (index 7), both inclusive.
- R4: Mode register (index 1) bit 29 enables an inner horizontal window (index 8, packed like index 5). Bit 30 enables an inner vertical window (indices 9 and 10, packed like 6 and 7). A data-enabled pixel outside an enabled inner window outputs the border colour (index 11) with select code 2.
- R5: A data-enabled pixel inside the inner window asserts the pixel request. If pix_valid is high, it passes pix_in with select code 1. Otherwise it outputs the underflow colour (index 12) with select code 3. Outside data-enable, the select is 0 and the pixel data is 0.
- R6: Polarity register (index 13) bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de. A polarity write takes effect on the next cycle, without waiting for a frame boundary.
- R7: When mode bit 31 is set, fetch_start pulses for exactly the one cycle in which the frame position equals the fetch-position register (index 14).
- R8: Bit 0 of the control register (index 0) runs the engine. On the cycle after it is set, all counters start from 0. While it is clear, the raw syncs, data-enable, pixel request and fetch pulse are inactive, and the counters read as 0.
- R9: The frame counter (read at index 15) increments at each frame-position wrap. The line counter (read at index 16) increments at each in-line wrap and returns to 0 at frame start.
- R10: Timing and mode registers (indices 1 to 10 and 14) written while the engine runs take effect at the next frame-position wrap. Reads return the value last written at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register index for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register index for reads |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pix_in | input | CW | Live pixel from upstream |
| pix_valid | input | 1 | Live pixel available |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data-enable after polarity |
| pix_req | output | 1 | Live pixel requested this cycle |
| pix_sel | output | 2 | Pixel source: 0 blank, 1 live, 2 border, 3 underflow |
| pix_data | output | CW | Selected pixel value |
| fetch_start | output | 1 | Programmable fetch-start pulse |

## Verification
The assertions check the following on every cycle: both position counters advance by one between wraps, the line counter is zero at frame start, the engine is quiet while stopped, a pixel request only occurs inside data-enable, the underflow source appears only when live data is absent, and the fetch pulse is one cycle wide. Other behaviours can only be shown by the bench's scenarios, because they depend on programmed values: the exact window edges, the border and inner-window decisions, polarity, the counter read values, and the deferral of a timing write to the next frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int DW  = 32;
    localparam int HW  = 16;
    localparam int AW  = 5;

    // Register indices of the programming port
    typedef enum logic [AW-1:0] {
        RI_CTRL      = 5'd0,
        RI_MODE      = 5'd1,
        RI_HTIME     = 5'd2,
        RI_VPERIOD   = 5'd3,
        RI_VPULSE    = 5'd4,
        RI_HDISP     = 5'd5,
        RI_VDISP_BEG = 5'd6,
        RI_VDISP_END = 5'd7,
        RI_HACT      = 5'd8,
        RI_VACT_BEG  = 5'd9,
        RI_VACT_END  = 5'd10,
        RI_BORDER    = 5'd11,
        RI_UNDER     = 5'd12,
        RI_POL       = 5'd13,
        RI_FETCH     = 5'd14,
        RI_FRAMES    = 5'd15,
        RI_LINES     = 5'd16
    } reg_idx_e;

    localparam int MODE_HACT_BIT  = 29;
    localparam int MODE_VACT_BIT  = 30;
    localparam int MODE_FETCH_BIT = 31;

    typedef enum logic [1:0] {
        SRC_BLANK  = 2'd0,
        SRC_LIVE   = 2'd1,
        SRC_BORDER = 2'd2,
        SRC_UNDER  = 2'd3
    } pix_src_e;

    // Frame-shadowed timing set
    typedef struct packed {
        logic [HW-1:0] h_total;
        logic [HW-1:0] h_pulse;
        logic [DW-1:0] v_period;
        logic [DW-1:0] v_pulse;
        logic [HW-1:0] dh_end;
        logic [HW-1:0] dh_start;
        logic [DW-1:0] dv_beg;
        logic [DW-1:0] dv_end;
        logic [HW-1:0] ah_end;
        logic [HW-1:0] ah_start;
        logic [DW-1:0] av_beg;
        logic [DW-1:0] av_end;
        logic          hact_en;
        logic          vact_en;
        logic          fetch_en;
        logic [DW-1:0] fetch_pos;
    } timing_t;

endpackage

// File: rtl/dtg_regs.sv
// Register file of the timing generator.
// Holds a staged copy of every timing field, written by the port, and a live
// copy that follows the staged one while stopped and at each frame wrap.
// Colours and polarity act immediately. Assumes CW <= 32.
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int CW    = 24,
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic           frame_wrap,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic [CNT_W-1:0] line_cnt,
    output timing_t        live,
    output logic           running,
    output logic [CW-1:0]  border_clr,
    output logic [CW-1:0]  under_clr,
    output logic [2:0]     pol
);

    timing_t staged;

    // Port writes into staged and immediate registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged     <= '0;
            running    <= 1'b0;
            border_clr <= '0;
            under_clr  <= '0;
            pol        <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RI_CTRL:      running <= wr_data[0];
                RI_MODE: begin
                    staged.hact_en  <= wr_data[MODE_HACT_BIT];
                    staged.vact_en  <= wr_data[MODE_VACT_BIT];
                    staged.fetch_en <= wr_data[MODE_FETCH_BIT];
                end
                RI_HTIME: begin
                    staged.h_total <= wr_data[31:16];
                    staged.h_pulse <= wr_data[15:0];
                end
                RI_VPERIOD:   staged.v_period <= wr_data;
                RI_VPULSE:    staged.v_pulse  <= wr_data;
                RI_HDISP: begin
                    staged.dh_end   <= wr_data[31:16];
                    staged.dh_start <= wr_data[15:0];
                end
                RI_VDISP_BEG: staged.dv_beg <= wr_data;
                RI_VDISP_END: staged.dv_end <= wr_data;
                RI_HACT: begin
                    staged.ah_end   <= wr_data[31:16];
                    staged.ah_start <= wr_data[15:0];
                end
                RI_VACT_BEG:  staged.av_beg <= wr_data;
                RI_VACT_END:  staged.av_end <= wr_data;
                RI_BORDER:    border_clr <= wr_data[CW-1:0];
                RI_UNDER:     under_clr  <= wr_data[CW-1:0];
                RI_POL:       pol        <= wr_data[2:0];
                RI_FETCH:     staged.fetch_pos <= wr_data;
                default: ;
            endcase
        end
    end

    // Live copy follows staged while stopped and at each frame wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (!running || frame_wrap) begin
            live <= staged;
        end
    end

    // Read-back multiplexer; counters read zero while stopped
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RI_CTRL:      rd_data = {31'd0, running};
            RI_MODE:      rd_data = {staged.fetch_en, staged.vact_en, staged.hact_en, 29'd0};
            RI_HTIME:     rd_data = {staged.h_total, staged.h_pulse};
            RI_VPERIOD:   rd_data = staged.v_period;
            RI_VPULSE:    rd_data = staged.v_pulse;
            RI_HDISP:     rd_data = {staged.dh_end, staged.dh_start};
            RI_VDISP_BEG: rd_data = staged.dv_beg;
            RI_VDISP_END: rd_data = staged.dv_end;
            RI_HACT:      rd_data = {staged.ah_end, staged.ah_start};
            RI_VACT_BEG:  rd_data = staged.av_beg;
            RI_VACT_END:  rd_data = staged.av_end;
            RI_BORDER:    rd_data = DW'(border_clr);
            RI_UNDER:     rd_data = DW'(under_clr);
            RI_POL:       rd_data = {29'd0, pol};
            RI_FETCH:     rd_data = staged.fetch_pos;
            RI_FRAMES:    rd_data = running ? DW'(frame_cnt) : '0;
            RI_LINES:     rd_data = running ? DW'(line_cnt)  : '0;
            default:      rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dtg_counters.sv
// Position and event counters of the timing generator.
// The in-line position wraps at the line total and the frame position wraps
// at the frame period. All counters are held at zero while stopped.
// Assumes the frame period is a multiple of the line total.
module dtg_counters
    import dtg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [HW-1:0]    h_total,
    input  logic [DW-1:0]    v_period,
    output logic [HW-1:0]    hpos,
    output logic [DW-1:0]    fpos,
    output logic [CNT_W-1:0] line_cnt,
    output logic [CNT_W-1:0] frame_cnt,
    output logic             frame_wrap
);

    logic line_wrap;

    assign line_wrap  = run && (hpos == h_total - HW'(1));
    assign frame_wrap = run && (fpos == v_period - DW'(1));

    // In-line pixel position
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  hpos <= '0;
        else if (line_wrap)  hpos <= '0;
        else                 hpos <= hpos + HW'(1);
    end

    // Frame pixel-clock position
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  fpos <= '0;
        else if (frame_wrap) fpos <= '0;
        else                 fpos <= fpos + DW'(1);
    end

    // Line and frame event counters
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            line_cnt  <= '0;
            frame_cnt <= '0;
        end else if (frame_wrap) begin
            line_cnt  <= '0;
            frame_cnt <= frame_cnt + CNT_W'(1);
        end else if (line_wrap) begin
            line_cnt  <= line_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dtg_decode.sv
// Window decode and pixel source selection.
// Purely combinational: compares the registered positions against the live
// timing set and picks the pixel source. Outputs are raw (before polarity).
module dtg_decode
    import dtg_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          run,
    input  timing_t       live,
    input  logic [HW-1:0] hpos,
    input  logic [DW-1:0] fpos,
    input  logic [CW-1:0] border_clr,
    input  logic [CW-1:0] under_clr,
    input  logic [CW-1:0] pix_in,
    input  logic          pix_valid,
    output logic          hs_raw,
    output logic          vs_raw,
    output logic          de_raw,
    output logic          pix_req,
    output logic [1:0]    pix_sel,
    output logic [CW-1:0] pix_data,
    output logic          fetch_pulse
);

    logic in_dh, in_dv, in_ah, in_av, inner;

    // Window membership tests
    always_comb begin
        in_dh = (hpos >= live.dh_start) && (hpos <= live.dh_end);
        in_dv = (fpos >= live.dv_beg)   && (fpos <= live.dv_end);
        in_ah = !live.hact_en || ((hpos >= live.ah_start) && (hpos <= live.ah_end));
        in_av = !live.vact_en || ((fpos >= live.av_beg)   && (fpos <= live.av_end));
        inner = in_ah && in_av;
    end

    // Sync, enable and fetch strobes
    always_comb begin
        hs_raw      = run && (hpos < live.h_pulse);
        vs_raw      = run && (fpos < live.v_pulse);
        de_raw      = run && in_dh && in_dv;
        pix_req     = de_raw && inner;
        fetch_pulse = run && live.fetch_en && (fpos == live.fetch_pos);
    end

    // Pixel source choice
    always_comb begin
        if (!de_raw) begin
            pix_sel  = SRC_BLANK;
            pix_data = '0;
        end else if (!inner) begin
            pix_sel  = SRC_BORDER;
            pix_data = border_clr;
        end else if (pix_valid) begin
            pix_sel  = SRC_LIVE;
            pix_data = pix_in;
        end else begin
            pix_sel  = SRC_UNDER;
            pix_data = under_clr;
        end
    end

endmodule

// File: rtl/display_timing_gen.sv
// Top level of the register-programmed display timing generator.
// Ties the register file, counters and decoder together and applies output
// polarity. Single pixel-clock domain, synchronous active-low reset.
module display_timing_gen
    import dtg_pkg::*;
#(
    parameter int CW    = 24,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [4:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [4:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic [CW-1:0] pix_in,
    input  logic          pix_valid,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_req,
    output logic [1:0]    pix_sel,
    output logic [CW-1:0] pix_data,
    output logic          fetch_start
);

    timing_t          live;
    logic             running;
    logic [CW-1:0]    border_clr, under_clr;
    logic [2:0]       pol;
    logic [HW-1:0]    hpos;
    logic [DW-1:0]    fpos;
    logic [CNT_W-1:0] line_cnt, frame_cnt;
    logic             frame_wrap;
    logic             hs_raw, vs_raw, de_raw;

    dtg_regs #(.CW(CW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_wrap(frame_wrap), .frame_cnt(frame_cnt), .line_cnt(line_cnt),
        .live(live), .running(running),
        .border_clr(border_clr), .under_clr(under_clr), .pol(pol)
    );

    dtg_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(running),
        .h_total(live.h_total), .v_period(live.v_period),
        .hpos(hpos), .fpos(fpos),
        .line_cnt(line_cnt), .frame_cnt(frame_cnt), .frame_wrap(frame_wrap)
    );

    dtg_decode #(.CW(CW)) u_dec (
        .run(running), .live(live), .hpos(hpos), .fpos(fpos),
        .border_clr(border_clr), .under_clr(under_clr),
        .pix_in(pix_in), .pix_valid(pix_valid),
        .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw),
        .pix_req(pix_req), .pix_sel(pix_sel), .pix_data(pix_data),
        .fetch_pulse(fetch_start)
    );

    // Output polarity
    always_comb begin
        hsync = hs_raw ^ pol[0];
        vsync = vs_raw ^ pol[1];
        de    = de_raw ^ pol[2];
    end

endmodule

// File: rtl/dtg_checker.sv
// Cycle-level properties of the timing generator, bound to the top module.
module dtg_checker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [15:0]      hpos,
    input  logic [31:0]      fpos,
    input  logic [CNT_W-1:0] line_cnt,
    input  logic             de_raw,
    input  logic             pix_req,
    input  logic [1:0]       pix_sel,
    input  logic             pix_valid,
    input  logic             fetch_start
);

    // R1
    hpos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && hpos != 16'd0) |-> (hpos == $past(hpos) + 16'd1));

    // R2
    fpos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && fpos != 32'd0) |-> (fpos == $past(fpos) + 32'd1));

    // R9
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && fpos == 32'd0) |-> (line_cnt == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!de_raw && !pix_req && !fetch_start && pix_sel == 2'd0));

    // R5
    req_in_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> de_raw);

    // R5
    under_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sel == 2'd3) |-> (!pix_valid && pix_req));

    // R7
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> !fetch_start);

endmodule

bind display_timing_gen dtg_checker #(.CNT_W(CNT_W)) u_dtg_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .hpos(hpos), .fpos(fpos),
    .line_cnt(line_cnt), .de_raw(de_raw), .pix_req(pix_req),
    .pix_sel(pix_sel), .pix_valid(pix_valid), .fetch_start(fetch_start)
);

// File: tb/display_timing_gen_bench.sv
module display_timing_gen_bench;

    localparam int CW = 24;
    localparam logic [23:0] BORDER = 24'h00FF00;
    localparam logic [23:0] UFLOW  = 24'hFF0000;
    localparam logic [23:0] LIVE   = 24'h123456;

    // Probe table: {t, hs, vs, de, fetch, sel} with line 12, frame 72 clocks
    localparam logic [21:0] VEC [16] = '{
        {16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
        {16'd3,   1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {16'd13,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        {16'd28,  1'b0, 1'b0, 1'b1, 1'b0, 2'd2},
        {16'd40,  1'b0, 1'b0, 1'b1, 1'b0, 2'd2},
        {16'd41,  1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
        {16'd44,  1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
        {16'd45,  1'b0, 1'b0, 1'b1, 1'b0, 2'd2},
        {16'd48,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        {16'd57,  1'b0, 1'b0, 1'b1, 1'b0, 2'd2},
        {16'd59,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {16'd60,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        {16'd65,  1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
        {16'd66,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {16'd76,  1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {16'd100, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [4:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [CW-1:0] pix_in = LIVE;
    logic          pix_valid = 1'b1;
    logic          hsync, vsync, de, pix_req, fetch_start;
    logic [1:0]    pix_sel;
    logic [CW-1:0] pix_data;

    int checks = 0;
    int errors = 0;
    int cur_t  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    display_timing_gen u_display_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_in(pix_in), .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_req(pix_req), .pix_sel(pix_sel), .pix_data(pix_data),
        .fetch_start(fetch_start)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%h expected=%h", req, cur_t, act, exp);
        end
    endtask

    // One register write; consumes one clock, called at a falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        cur_t++;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic go_to(input int t);
        repeat (t - cur_t) @(negedge clk);
        cur_t = t;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state, engine stopped
        check("R8 hsync idle", hsync, 0);
        check("R8 de idle", de, 0);
        check("R8 sel idle", pix_sel, 0);
        rd(5'd15, v); check("R8 frames idle", v, 0);

        wr(5'd1,  32'hE000_0000);
        wr(5'd2,  32'h000C_0002);
        wr(5'd3,  32'd72);
        wr(5'd4,  32'd12);
        wr(5'd5,  32'h0009_0004);
        wr(5'd6,  32'd24);
        wr(5'd7,  32'd59);
        wr(5'd8,  32'h0008_0005);
        wr(5'd9,  32'd36);
        wr(5'd10, 32'd47);
        wr(5'd11, 32'(BORDER));
        wr(5'd12, 32'(UFLOW));
        wr(5'd13, 32'd0);
        wr(5'd14, 32'd65);
        rd(5'd1, v); check("R10 mode readback", v, 32'hE000_0000);
        wr(5'd0, 32'd1);
        cur_t = 0;

        // Table walk: R1 R2 R3 R4 R7 R9
        for (int i = 0; i < 16; i++) begin
            int t;
            t = int'(VEC[i][21:6]);
            go_to(t);
            check("R1 hsync", hsync, VEC[i][5]);
            check("R2 vsync", vsync, VEC[i][4]);
            check("R3 de", de, VEC[i][3]);
            check("R7 fetch", fetch_start, VEC[i][2]);
            check("R4 sel", pix_sel, VEC[i][1:0]);
            if (VEC[i][1:0] == 2'd1) check("R5 live data", pix_data, LIVE);
            if (VEC[i][1:0] == 2'd2) check("R4 border data", pix_data, BORDER);
            rd(5'd16, v); check("R9 line", v, (t % 72) / 12);
            rd(5'd15, v); check("R9 frame", v, t / 72);
        end

        // R6: polarity inversion, immediate
        wr(5'd13, 32'd7);
        go_to(108);
        check("R6 hsync inv", hsync, 0);
        check("R6 vsync inv", vsync, 1);
        check("R6 de inv", de, 1);
        wr(5'd13, 32'd0);

        // R5: underflow substitution
        pix_valid = 1'b0;
        go_to(113);
        check("R5 under sel", pix_sel, 3);
        check("R5 under data", pix_data, UFLOW);
        check("R5 req", pix_req, 1);
        go_to(117);
        check("R4 border sel", pix_sel, 2);
        check("R4 border data", pix_data, BORDER);
        pix_valid = 1'b1;

        // R10: timing write deferred to next frame
        wr(5'd2, 32'h000C_0005);
        rd(5'd2, v); check("R10 readback", v, 32'h000C_0005);
        go_to(124);
        check("R10 old pulse kept", hsync, 0);
        go_to(147);
        check("R10 new pulse at frame", hsync, 1);
        rd(5'd15, v); check("R9 frame two", v, 2);

        // R8: stop then restart
        wr(5'd0, 32'd0);
        check("R8 de stopped", de, 0);
        rd(5'd15, v); check("R8 frames zero", v, 0);
        rd(5'd16, v); check("R8 lines zero", v, 0);
        wr(5'd0, 32'd1);
        cur_t = 0;
        check("R8 restart hsync", hsync, 1);
        rd(5'd16, v); check("R8 restart line", v, 0);
        go_to(4);
        check("R1 pulse 5 in", hsync, 1);
        go_to(5);
        check("R1 pulse 5 out", hsync, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule